// File: doc/BRIEF.md
# Two-Input First-Come Merge Joint

This block joins two producer links onto one consumer link. Each input link presents a word and a "full" flag. The output link reports whether it is still occupied. When the go enable is high, the output link is empty and at least one input link holds a word, the joint fires. In that cycle it copies one input word onto the output, pulses a fill strobe toward the output link and pulses a drain strobe toward the chosen input link. The links take these strobes at the next rising clock edge.

The choice between the inputs depends on when each word arrived. It does not depend on a fixed priority or a rotating pointer. An input whose word has waited longer is served first. When both words arrive in the same cycle, a stored preference bit picks the winner, and that bit flips after every such tie. The word that loses stays in its link untouched until a later firing takes it. The output stream is therefore always an interleaving of the two input streams, and each stream keeps its own order.

Top module: `merge_joint`

## Requirements
- R1: In any cycle, at most one of `a_drain` and `b_drain` is high.
- R2: Suppose one input link has held an undrained word since an earlier cycle and the other input link only became full in the current cycle. A firing in this cycle then drains the older input.
- R3: `out_fill` is high exactly when `go` is 1, `out_full` is 0 and at least one of `a_full` and `b_full` is 1. When `out_fill` is low, both drain strobes are low.
- R4: In a firing cycle, `out_data` equals the data word of the granted input. Exactly that input's drain strobe is high in the same cycle.
- R5: If both input links are newly full in the same cycle, that counts as a tie. The first tie after reset is granted to input A. Each later tie goes to the input that lost the previous tie. Once a tie has been decided, the same order holds for that pair of words until one of them is drained.
- R6: When both inputs are full, the input that is not granted sees no drain strobe. Its word is delivered by a later firing.
- R7: Over any run, every input word appears on the output exactly once, and each input's words come out in the order they arrived.
- R8: While `rst_n` is 0, `out_fill`, `a_drain` and `b_drain` are all 0, whatever `go` and the full flags are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Firing enable |
| a_full | input | 1 | Input link A holds a word |
| a_data | input | WIDTH | Word held by input link A |
| a_drain | output | 1 | Empties input link A at the next edge |
| b_full | input | 1 | Input link B holds a word |
| b_data | input | WIDTH | Word held by input link B |
| b_drain | output | 1 | Empties input link B at the next edge |
| out_full | input | 1 | Output link is still occupied |
| out_data | output | WIDTH | Word written into the output link |
| out_fill | output | 1 | Fills the output link at the next edge |

## Verification
The bench aims at four corner cases:
- Tie sequence. Both links fill in the same cycle, several times in a row, with and without `go` held low. A design that ignored the preference bit, or never flipped it, would always serve the same input first.
- Arrival skew. One word waits while the other arrives one cycle later. Arbitration by fixed priority would serve the newcomer first and reorder the output.
- Blocking. `go` is held low, or the output link is kept full. A design that leaked a firing there would overwrite an unread output word or drain an input word without delivering it.
- Random traffic. Tagged random streams with random gating check that no word is lost, doubled or reordered within its own stream.

// File: rtl/merge_joint.sv
module merge_joint #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             a_full,
  input  logic [WIDTH-1:0] a_data,
  output logic             a_drain,
  input  logic             b_full,
  input  logic [WIDTH-1:0] b_data,
  output logic             b_drain,
  input  logic             out_full,
  output logic [WIDTH-1:0] out_data,
  output logic             out_fill
);

  logic a_old, b_old;
  logic head_b;
  logic tie_pref_b;

  logic a_new, b_new, both, tie, pick_both_b, pick_b, fire;

  assign a_new = a_full & ~a_old;
  assign b_new = b_full & ~b_old;
  assign both  = a_full & b_full;
  assign tie   = both & a_new & b_new;

  assign pick_both_b = tie             ? tie_pref_b :
                       (a_old & b_new) ? 1'b0       :
                       (b_old & a_new) ? 1'b1       :
                                         head_b;

  assign pick_b   = both ? pick_both_b : b_full;
  assign fire     = rst_n & go & ~out_full & (a_full | b_full);
  assign out_fill = fire;
  assign a_drain  = fire & ~pick_b;
  assign b_drain  = fire & pick_b;
  assign out_data = pick_b ? b_data : a_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_old      <= 1'b0;
      b_old      <= 1'b0;
      head_b     <= 1'b0;
      tie_pref_b <= 1'b0;
    end else begin
      a_old <= a_full & ~a_drain;
      b_old <= b_full & ~b_drain;
      if (both & ~a_drain & ~b_drain)
        head_b <= pick_both_b;
      if (tie)
        tie_pref_b <= ~tie_pref_b;
    end
  end

  AST_ONE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_drain && b_drain)); // R1

  AST_A_OLDER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fill && a_full && b_full && $past(a_full && !a_drain) && !$past(b_full && !b_drain))
      |-> a_drain); // R2

  AST_B_OLDER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fill && a_full && b_full && $past(b_full && !b_drain) && !$past(a_full && !a_drain))
      |-> b_drain); // R2

  AST_FIRE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    out_fill |-> (go && !out_full)); // R3

  AST_DRAIN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drain |-> a_full) and (b_drain |-> b_full)); // R3

  AST_FILL_ONE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_fill |-> ($countones({a_drain, b_drain}) == 1)); // R4

  AST_DATA_FROM_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fill && b_drain) |-> (out_data == b_data)); // R4

  AST_KEEP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (a_old && b_old && !a_drain && !b_drain) |=> !(a_drain && b_drain)); // R6

  always_comb begin
    if (!rst_n)
      AST_RESET_QUIET: assert (!out_fill && !a_drain && !b_drain); // R8
  end

endmodule

// File: tb/test_merge_joint.sv
module test_merge_joint;
  localparam int PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic a_full = 1'b0, b_full = 1'b0, out_full = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic a_drain, b_drain, out_fill;
  logic [W-1:0] out_data;

  merge_joint #(.WIDTH(W)) i_merge_joint (
    .clk(clk), .rst_n(rst_n), .go(go),
    .a_full(a_full), .a_data(a_data), .a_drain(a_drain),
    .b_full(b_full), .b_data(b_data), .b_drain(b_drain),
    .out_full(out_full), .out_data(out_data), .out_fill(out_fill)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit la_full = 0, lb_full = 0, lo_full = 0;
  logic [W-1:0] la_data = '0, lb_data = '0;
  int la_t = 0, lb_t = 0;
  int sa = 0, sb = 0, na = 0, nb = 0;
  bit tie_pref = 0, tie_w = 0;
  bit last_win = 0, last_fire = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [W-1:0] tag(input bit src, input int seq);
    return {src, seq[W-2:0]};
  endfunction

  task automatic step(input bit fa, input bit fb, input bit g, input bit cons);
    bit win;
    bit efire;
    @(negedge clk);
    if (fa && !la_full) begin la_full = 1; la_data = tag(1'b0, sa); sa++; la_t = cyc; end
    if (fb && !lb_full) begin lb_full = 1; lb_data = tag(1'b1, sb); sb++; lb_t = cyc; end
    if (cons) lo_full = 0;
    a_full = la_full; a_data = la_data;
    b_full = lb_full; b_data = lb_data;
    out_full = lo_full; go = g;
    #(PERIOD/2 - 1);
    if (la_full && lb_full) begin
      if (la_t < lb_t) win = 0;
      else if (lb_t < la_t) win = 1;
      else if (la_t == cyc) begin win = tie_pref; tie_w = tie_pref; tie_pref = ~tie_pref; end
      else win = tie_w;
    end else win = lb_full;
    efire = g && !lo_full && (la_full || lb_full);
    check("R3", 32'(out_fill), 32'(efire));
    if (efire) begin
      check("R1", 32'(a_drain && b_drain), 32'd0);
      check("R4", 32'(b_drain), 32'(win));
      check("R4", 32'(out_data), 32'(win ? lb_data : la_data));
      if (la_full && lb_full)
        check("R6", 32'(win ? a_drain : b_drain), 32'd0);
      if (out_data[W-1] == 1'b0) begin
        check("R7", 32'(out_data[W-2:0]), 32'(na[W-2:0])); na++;
      end else begin
        check("R7", 32'(out_data[W-2:0]), 32'(nb[W-2:0])); nb++;
      end
      lo_full = 1;
      if (win) lb_full = 0; else la_full = 0;
    end else begin
      check("R3", 32'({a_drain, b_drain}), 32'd0);
    end
    last_win = win;
    last_fire = efire;
    cyc++;
  endtask

  initial begin
    #(PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R8: quiet during reset even with requests and go high
    a_full = 1; b_full = 1; go = 1;
    #(PERIOD*3 + 2);
    check("R8", 32'({out_fill, a_drain, b_drain}), 32'd0);
    @(negedge clk);
    a_full = 0; b_full = 0; go = 0;
    @(negedge clk);
    rst_n = 1;

    // R5: first tie after reset goes to A, held across go-low cycles
    step(1, 1, 0, 1);
    step(0, 0, 0, 1);
    step(0, 0, 1, 1);
    check("R5", 32'(last_win), 32'd0);
    step(0, 0, 1, 1);
    check("R6", 32'(last_win), 32'd1);
    // R5: second tie goes to B
    step(1, 1, 1, 1);
    check("R5", 32'(last_win), 32'd1);
    step(0, 0, 1, 1);
    check("R6", 32'(last_win), 32'd0);
    // R5: third tie back to A
    step(1, 1, 1, 1);
    check("R5", 32'(last_win), 32'd0);
    step(0, 0, 1, 1);

    // R2: A waits, B arrives later, A served first
    step(1, 0, 0, 1);
    step(0, 1, 1, 1);
    check("R2", 32'(last_win), 32'd0);
    step(0, 0, 1, 1);
    // R2: B waits, A arrives later, B served first
    step(0, 1, 0, 1);
    step(1, 0, 1, 1);
    check("R2", 32'(last_win), 32'd1);
    step(0, 0, 1, 1);

    // R3: output link full blocks firing
    step(1, 0, 1, 0);
    step(0, 1, 1, 0);
    check("R3", 32'(last_fire), 32'd0);
    step(0, 0, 1, 1);
    check("R3", 32'(last_fire), 32'd1);
    step(0, 0, 0, 1);
    check("R3", 32'(last_fire), 32'd0);
    step(0, 0, 1, 1);

    // random traffic
    for (int k = 0; k < 4000; k++)
      step(($urandom % 100) < 45, ($urandom % 100) < 45,
           ($urandom % 100) < 70, ($urandom % 100) < 60);

    for (int k = 0; k < 10; k++) step(0, 0, 1, 1);
    check("R7", 32'(na), 32'(sa));
    check("R7", 32'(nb), 32'(sb));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule